// File: doc/BRIEF.md
# Process-Tagged Page Translation Cache

This block keeps a small set of recently used page translations so that a memory access can be turned from a virtual address into a physical one without walking the page table. A 32-bit virtual address is cut into a 20-bit page number and a 12-bit byte offset. The page number and the requester's process tag are compared against every stored translation in the same cycle. When exactly one entry agrees, the stored 16-bit frame number is joined to the untouched offset to form a 28-bit physical address.

Each stored translation also holds a read-allowed and a write-allowed flag. An access whose type the matching entry forbids is reported as a protection fault, which is distinct from a miss, and no address is returned for it. Because every entry carries the process tag of its owner, translations from several processes can live side by side, and a context switch does not have to empty the cache. A separate flush input empties the cache when software needs that. After a miss, the walker outside this block loads the translation through the fill port. The fill goes to the slot named by a round-robin pointer.

Top module: `xlate_buffer`

## Requirements
- R1: After reset every lookup reports a miss, because all entries are invalid.
- R2: A lookup whose page number and process tag match exactly one valid entry, and whose access type that entry allows, raises hit in the same cycle. The physical address is then {stored frame number, vaddr[11:0]}.
- R3: An entry whose process tag differs from the lookup's tag never matches, even if its page number is equal.
- R4: On a single match where the access is forbidden, fault is raised instead of hit, and the physical address is zero. A write is forbidden when the write flag is 0, and a read is forbidden when the read flag is 0. The physical address is zero whenever hit is low.
- R5: A flush clears every entry in one clock. A lookup made in the flush cycle reports a miss, and so do lookups of the flushed translations afterwards.
- R6: Fills go to slots 0, 1, 2 and onward in round-robin order, wrapping after the last slot. After 65 fills following a flush, the first translation has been replaced and the second is still present.
- R7: If two or more valid entries match the same page number and process tag, the lookup reports a miss.
- R8: While a lookup is requested, exactly one of hit, miss and fault is high. With no lookup requested, all three are low.
- R9: A fill is written at the clock edge and sets the slot's valid flag at that edge. A lookup in the fill cycle sees the old contents, and the next cycle sees the new translation.
- R10: A fill presented in the same cycle as a flush is dropped, and the round-robin pointer returns to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_pid | input | 8 | Process tag of the requester |
| lk_hit | output | 1 | Translation found and access allowed |
| lk_miss | output | 1 | No usable translation |
| lk_fault | output | 1 | Translation found but access type forbidden |
| lk_paddr | output | 28 | Physical address, valid with lk_hit |
| fill_en | input | 1 | Load one translation |
| fill_vpn | input | 20 | Virtual page number to load |
| fill_pid | input | 8 | Process tag to load |
| fill_pfn | input | 16 | Physical frame number to load |
| fill_rd | input | 1 | Read-allowed flag to load |
| fill_wr | input | 1 | Write-allowed flag to load |
| flush | input | 1 | Invalidate all entries |

## Verification
The assertions check on every cycle that the three outcome signals are mutually exclusive and silent when no lookup is requested, that a flush-cycle lookup misses, that a flush leaves no valid entry and resets the pointer, that each fill sets its slot's valid flag and advances the pointer by one, and that the offset passes through on a hit while the address is zero otherwise. Several behaviours can only be seen through the bench's scenarios: that the right frame comes back for a given page and process, the separation between processes, the read and write permission faults, the miss on duplicate entries, the eviction order after a full round of fills, and that a fill made together with a flush is lost.

// File: rtl/xb_pkg.sv
package xb_pkg;
  typedef enum logic [1:0] {
    XB_NONE  = 2'd0,
    XB_MISS  = 2'd1,
    XB_HIT   = 2'd2,
    XB_FAULT = 2'd3
  } xb_outcome_t;
endpackage

// File: rtl/xb_store.sv
module xb_store #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PID_W   = 8,
  parameter int PFN_W   = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            flush,
  input  logic                            fill_en,
  input  logic [VPN_W-1:0]                fill_vpn,
  input  logic [PID_W-1:0]                fill_pid,
  input  logic [PFN_W-1:0]                fill_pfn,
  input  logic                            fill_rd,
  input  logic                            fill_wr,
  output logic [ENTRIES-1:0]              ent_valid,
  output logic [ENTRIES-1:0][VPN_W-1:0]   ent_vpn,
  output logic [ENTRIES-1:0][PID_W-1:0]   ent_pid,
  output logic [ENTRIES-1:0][PFN_W-1:0]   ent_pfn,
  output logic [ENTRIES-1:0]              ent_rd,
  output logic [ENTRIES-1:0]              ent_wr
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr;
  logic             do_fill;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign do_fill = fill_en && !flush;

  always_ff @(posedge clk) begin
    if (rst || flush) ptr <= '0;
    else if (do_fill) ptr <= step(ptr);
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic sel;
    assign sel = do_fill && (ptr == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst || flush) ent_valid[i] <= 1'b0;
      else if (sel)     ent_valid[i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        ent_vpn[i] <= fill_vpn;
        ent_pid[i] <= fill_pid;
        ent_pfn[i] <= fill_pfn;
        ent_rd[i]  <= fill_rd;
        ent_wr[i]  <= fill_wr;
      end
    end
  end

  assert_flush_clears_R5: assert property (@(posedge clk) disable iff (rst)
    flush |=> (ent_valid == '0));
  assert_ptr_home_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (ptr == '0));
  assert_fill_sets_valid_R9: assert property (@(posedge clk) disable iff (rst)
    do_fill |=> ent_valid[$past(ptr)]);
  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (rst)
    do_fill |=> (ptr == step($past(ptr))));
  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!fill_en && !flush) |=> $stable(ptr));
endmodule

// File: rtl/xb_match.sv
module xb_match #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PID_W   = 8,
  parameter int PFN_W   = 16
) (
  input  logic [ENTRIES-1:0]              ent_valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0]   ent_vpn,
  input  logic [ENTRIES-1:0][PID_W-1:0]   ent_pid,
  input  logic [ENTRIES-1:0][PFN_W-1:0]   ent_pfn,
  input  logic [ENTRIES-1:0]              ent_rd,
  input  logic [ENTRIES-1:0]              ent_wr,
  input  logic [VPN_W-1:0]                key_vpn,
  input  logic [PID_W-1:0]                key_pid,
  output logic                            single,
  output logic [PFN_W-1:0]                sel_pfn,
  output logic                            sel_rd,
  output logic                            sel_wr
);
  logic [ENTRIES-1:0] m;
  logic               multi;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign m[i] = ent_valid[i] && (ent_vpn[i] == key_vpn) && (ent_pid[i] == key_pid);
  end

  assign multi  = |(m & (m - 1'b1));
  assign single = (|m) && !multi;

  always_comb begin
    sel_pfn = '0;
    sel_rd  = 1'b0;
    sel_wr  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      sel_pfn = sel_pfn | ({PFN_W{m[i]}} & ent_pfn[i]);
      sel_rd  = sel_rd  | (m[i] & ent_rd[i]);
      sel_wr  = sel_wr  | (m[i] & ent_wr[i]);
    end
  end

  always_comb begin
    if (single) assert_single_onehot_R7: assert ($onehot(m));
  end
endmodule

// File: rtl/xlate_buffer.sv
module xlate_buffer #(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PA_W    = 28,
  parameter int PID_W   = 8,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PFN_W  = PA_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic              lk_write,
  input  logic [PID_W-1:0]  lk_pid,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_fault,
  output logic [PA_W-1:0]   lk_paddr,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PID_W-1:0]  fill_pid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              fill_rd,
  input  logic              fill_wr,
  input  logic              flush
);
  import xb_pkg::*;

  logic [ENTRIES-1:0]             ent_valid;
  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn;
  logic [ENTRIES-1:0][PID_W-1:0]  ent_pid;
  logic [ENTRIES-1:0][PFN_W-1:0]  ent_pfn;
  logic [ENTRIES-1:0]             ent_rd;
  logic [ENTRIES-1:0]             ent_wr;
  logic                           single;
  logic [PFN_W-1:0]               sel_pfn;
  logic                           sel_rd;
  logic                           sel_wr;
  logic                           allowed;
  xb_outcome_t                    outcome;

  xb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W), .PFN_W(PFN_W)) u_store (
    .clk(clk), .rst(rst), .flush(flush), .fill_en(fill_en),
    .fill_vpn(fill_vpn), .fill_pid(fill_pid), .fill_pfn(fill_pfn),
    .fill_rd(fill_rd), .fill_wr(fill_wr),
    .ent_valid(ent_valid), .ent_vpn(ent_vpn), .ent_pid(ent_pid),
    .ent_pfn(ent_pfn), .ent_rd(ent_rd), .ent_wr(ent_wr)
  );

  xb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W), .PFN_W(PFN_W)) u_match (
    .ent_valid(ent_valid), .ent_vpn(ent_vpn), .ent_pid(ent_pid),
    .ent_pfn(ent_pfn), .ent_rd(ent_rd), .ent_wr(ent_wr),
    .key_vpn(lk_vaddr[VA_W-1:OFF_W]), .key_pid(lk_pid),
    .single(single), .sel_pfn(sel_pfn), .sel_rd(sel_rd), .sel_wr(sel_wr)
  );

  assign allowed = lk_write ? sel_wr : sel_rd;

  always_comb begin
    if (!lk_valid)            outcome = XB_NONE;
    else if (flush || !single) outcome = XB_MISS;
    else if (!allowed)        outcome = XB_FAULT;
    else                      outcome = XB_HIT;
  end

  assign lk_hit   = (outcome == XB_HIT);
  assign lk_miss  = (outcome == XB_MISS);
  assign lk_fault = (outcome == XB_FAULT);
  assign lk_paddr = lk_hit ? {sel_pfn, lk_vaddr[OFF_W-1:0]} : '0;

  assert_one_result_R8: assert property (@(posedge clk) disable iff (rst)
    lk_valid |-> $onehot({lk_hit, lk_miss, lk_fault}));
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> !(lk_hit || lk_miss || lk_fault));
  assert_flush_miss_R5: assert property (@(posedge clk) disable iff (rst)
    (flush && lk_valid) |-> lk_miss);
  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));
  assert_nohit_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_paddr == '0));
endmodule

// File: tb/xlate_buffer_tb_top.sv
module xlate_buffer_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic        lk_write;
  logic [7:0]  lk_pid;
  logic        lk_hit, lk_miss, lk_fault;
  logic [27:0] lk_paddr;
  logic        fill_en;
  logic [19:0] fill_vpn;
  logic [7:0]  fill_pid;
  logic [15:0] fill_pfn;
  logic        fill_rd, fill_wr, flush;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // outcome codes used by the bench: 0 miss, 1 hit, 2 fault, 3 none
  localparam logic [1:0] C_MISS = 2'd0, C_HIT = 2'd1, C_FAULT = 2'd2, C_NONE = 2'd3;

  // {pid, vaddr, write, outcome, paddr}
  localparam logic [70:0] VEC [0:9] = '{
    {8'd1, 32'h00010ABC, 1'b0, C_HIT,   28'h0A00ABC},
    {8'd1, 32'h00010123, 1'b1, C_HIT,   28'h0A00123},
    {8'd2, 32'h00010FFF, 1'b0, C_HIT,   28'h0C22FFF},
    {8'd1, 32'h00011000, 1'b0, C_HIT,   28'h0B11000},
    {8'd1, 32'h00011004, 1'b1, C_FAULT, 28'h0000000},
    {8'd3, 32'h00010000, 1'b0, C_MISS,  28'h0000000},
    {8'd1, 32'h00012000, 1'b0, C_MISS,  28'h0000000},
    {8'd1, 32'hFFFFF7FF, 1'b1, C_HIT,   28'hFFFF7FF},
    {8'd1, 32'hFFFFF7FF, 1'b0, C_FAULT, 28'h0000000},
    {8'd2, 32'h00011000, 1'b0, C_MISS,  28'h0000000}
  };

  xlate_buffer dut_i (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_write(lk_write), .lk_pid(lk_pid), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_fault(lk_fault), .lk_paddr(lk_paddr), .fill_en(fill_en),
    .fill_vpn(fill_vpn), .fill_pid(fill_pid), .fill_pfn(fill_pfn),
    .fill_rd(fill_rd), .fill_wr(fill_wr), .flush(flush)
  );

  always #5 clk = ~clk;

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic check(input string req, input logic [1:0] exp_c, input logic [27:0] exp_pa);
    logic [1:0] got;
    got = lk_hit ? C_HIT : lk_fault ? C_FAULT : lk_miss ? C_MISS : C_NONE;
    if ((lk_hit + lk_fault + lk_miss) > 1) got = 2'bxx;
    checks++;
    if (got !== exp_c || lk_paddr !== exp_pa) begin
      fails++;
      $display("FAIL %s: outcome=%0d paddr=%h expected outcome=%0d paddr=%h",
               req, got, lk_paddr, exp_c, exp_pa);
    end
  endtask

  task automatic set_lookup(input logic [7:0] pid, input logic [31:0] va, input logic wr);
    lk_valid = 1'b1; lk_pid = pid; lk_vaddr = va; lk_write = wr;
  endtask

  task automatic lookup(input string req, input logic [7:0] pid, input logic [31:0] va,
                        input logic wr, input logic [1:0] exp_c, input logic [27:0] exp_pa);
    @(negedge clk);
    set_lookup(pid, va, wr);
    #2 check(req, exp_c, exp_pa);
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [7:0] pid, input logic [15:0] pfn,
                      input logic rd, input logic wr);
    @(negedge clk);
    lk_valid = 1'b0;
    fill_en = 1'b1; fill_vpn = vpn; fill_pid = pid; fill_pfn = pfn;
    fill_rd = rd; fill_wr = wr;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_up();
  end

  initial begin
    rst = 1'b1; lk_valid = 1'b0; lk_vaddr = '0; lk_write = 1'b0; lk_pid = '0;
    fill_en = 1'b0; fill_vpn = '0; fill_pid = '0; fill_pfn = '0;
    fill_rd = 1'b0; fill_wr = 1'b0; flush = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: empty after reset
    lookup("R1", 8'd0, 32'h00000000, 1'b0, C_MISS, 28'h0);
    lookup("R1", 8'd1, 32'h00010ABC, 1'b0, C_MISS, 28'h0);
    // R8: no request, all outcomes low
    @(negedge clk); lk_valid = 1'b0;
    #2 check("R8", C_NONE, 28'h0);

    // R9: lookup in the fill cycle sees old contents, next cycle sees new
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = 20'h00010; fill_pid = 8'd1; fill_pfn = 16'h0A00;
    fill_rd = 1'b1; fill_wr = 1'b1;
    set_lookup(8'd1, 32'h00010ABC, 1'b0);
    #2 check("R9", C_MISS, 28'h0);
    @(negedge clk); fill_en = 1'b0;
    #2 check("R9", C_HIT, 28'h0A00ABC);

    fill(20'h00011, 8'd1, 16'h0B11, 1'b1, 1'b0);
    fill(20'h00010, 8'd2, 16'h0C22, 1'b1, 1'b1);
    fill(20'hFFFFF, 8'd1, 16'hFFFF, 1'b0, 1'b1);

    // R2, R3, R4: table of lookups
    for (int k = 0; k < 10; k++) begin
      logic [70:0] v;
      v = VEC[k];
      lookup((v[29:28] == C_HIT) ? "R2" : (v[29:28] == C_FAULT) ? "R4" : "R3",
             v[70:63], v[62:31], v[30], v[29:28], v[27:0]);
    end

    // R7: duplicate matching entries give a miss
    fill(20'h00020, 8'd1, 16'h0001, 1'b1, 1'b1);
    lookup("R7", 8'd1, 32'h00020000, 1'b0, C_HIT, 28'h0001000);
    fill(20'h00020, 8'd1, 16'h0002, 1'b1, 1'b1);
    lookup("R7", 8'd1, 32'h00020000, 1'b0, C_MISS, 28'h0);

    // R5, R10: lookup during flush misses, concurrent fill dropped
    @(negedge clk);
    flush = 1'b1;
    fill_en = 1'b1; fill_vpn = 20'h00030; fill_pid = 8'd1; fill_pfn = 16'h0333;
    fill_rd = 1'b1; fill_wr = 1'b1;
    set_lookup(8'd1, 32'h00010ABC, 1'b0);
    #2 check("R5", C_MISS, 28'h0);
    @(negedge clk); flush = 1'b0; fill_en = 1'b0;
    lookup("R5", 8'd1, 32'h00010ABC, 1'b0, C_MISS, 28'h0);
    lookup("R5", 8'd2, 32'h00010000, 1'b0, C_MISS, 28'h0);
    lookup("R10", 8'd1, 32'h00030000, 1'b0, C_MISS, 28'h0);

    // R6: full round of fills, then one more evicts the oldest
    for (int i = 0; i < 64; i++)
      fill(20'h00100 + 20'(i), 8'd5, 16'h2000 + 16'(i), 1'b1, 1'b1);
    lookup("R6", 8'd5, 32'h00100000, 1'b0, C_HIT, 28'h2000000);
    lookup("R6", 8'd5, 32'h0013F123, 1'b1, C_HIT, 28'h203F123);
    fill(20'h00200, 8'd5, 16'h3000, 1'b1, 1'b1);
    lookup("R6", 8'd5, 32'h00100000, 1'b0, C_MISS, 28'h0);
    lookup("R6", 8'd5, 32'h00101ABC, 1'b0, C_HIT, 28'h2001ABC);
    lookup("R6", 8'd5, 32'h00200FFF, 1'b0, C_HIT, 28'h3000FFF);

    @(negedge clk); lk_valid = 1'b0;
    #2 check("R8", C_NONE, 28'h0);
    finish_up();
  end
endmodule